// File: doc/BRIEF.md
# Interrupt Summary and Acknowledge Register

This block is a single 16-bit control/status register inside a communication controller. It gathers several groups of lower-level interrupt sources and reduces each group to one summary flag. It holds one enable per summary flag and drives a registered request line for each group. It also drives a module-level request line, which is raised when any enabled summary flag is active. The lower-level flag registers and the receive FIFO storage are outside the block. Their state arrives as flag and enable vectors, wakeup pulses and FIFO fill levels.

Software acknowledges a wakeup by writing one to its flag bit. A write of one to either receive-FIFO-not-empty flag bit pops that FIFO: the block advances the FIFO's read index, wrapping at the FIFO depth, and emits a one-cycle pop strobe. The flag then stays set if entries remain. The other summary flags cannot be cleared by software. They fall only when the lower-level state feeding them has cleared.

The register layout is as follows:

- Bits 15..8 are flags: 15 module, 14 protocol, 13 host-interface error, 12 wakeup, 11 FIFO B not empty, 10 FIFO A not empty, 9 receive buffer, 8 transmit buffer.
- Bits 7..0 hold the matching enables in the same order. Enable bit k belongs to flag bit k+8.
- Request line `irq_src[k]` belongs to flag bit k+8.

Top module: `irq_summary_reg`

## Requirements
- R1: After reset the register reads 0x0000, and every request line, both pop strobes and both read indexes are zero.
- R2: The protocol (bit 14), receive-buffer (bit 9) and transmit-buffer (bit 8) flags read one clock after their inputs change. Each reads as the OR, over its group, of each source flag ANDed with that source's own enable. Each reads zero once every source flag or source enable in the group is clear.
- R3: The host-interface error flag (bit 13) is set only when at least one host-interface error input is set and enable bit 5 was set on the previous clock.
- R4: The module flag (bit 15) reads one whenever any flag in bits 14..8 is set together with its enable in bits 6..0. It is not gated by enable bit 7.
- R5: `irq_src[k]` equals flag bit k+8 ANDed with enable bit k, and `irq_mod` equals bit 15 ANDed with bit 7. Each request line is a register that follows its inputs one clock later.
- R6: Every write loads bits 7..0. Writes to bits 15, 14, 13, 9 and 8 have no effect, and writing zero to bits 12, 11 or 10 leaves them unchanged.
- R7: A wakeup pulse on channel A or B sets bit 12 on the next clock. Writing one to bit 12 clears it.
- R8: When a wakeup pulse and a write of one to bit 12 occur in the same cycle, bit 12 stays set.
- R9: Writing one to bit 10 (FIFO A) or bit 11 (FIFO B) while that FIFO's level is nonzero gives a pop strobe for exactly one cycle, on the clock after the write. The same clock advances the FIFO's read index by one, wrapping from depth-1 to 0.
- R10: In the cycle after an accepted pop, the FIFO flag equals (level > 1). At all other times it follows (level != 0), one clock late.
- R11: Writing one to a FIFO flag bit while that FIFO's level is zero gives no strobe and leaves its read index unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| prot_flags | input | PROT_N | Protocol source flags |
| prot_en | input | PROT_N | Protocol source enables |
| hif_flags | input | HIF_N | Host-interface error flags |
| rxb_flags | input | RXB_N | Receive-buffer source flags |
| rxb_en | input | RXB_N | Receive-buffer source enables |
| txb_flags | input | TXB_N | Transmit-buffer source flags |
| txb_en | input | TXB_N | Transmit-buffer source enables |
| wake_a | input | 1 | Wakeup symbol seen on channel A (pulse) |
| wake_b | input | 1 | Wakeup symbol seen on channel B (pulse) |
| fifo_a_lvl | input | LVL_W | Entries held in receive FIFO A |
| fifo_b_lvl | input | LVL_W | Entries held in receive FIFO B |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 16 | Register write data |
| rd_data | output | 16 | Register read value |
| irq_src | output | 7 | Per-flag request lines, bit k for flag bit k+8 |
| irq_mod | output | 1 | Module request line |
| fifo_a_idx | output | IDX_W | FIFO A read index |
| fifo_b_idx | output | IDX_W | FIFO B read index |
| fifo_a_pop | output | 1 | FIFO A read-index advance strobe |
| fifo_b_pop | output | 1 | FIFO B read-index advance strobe |

## Verification
The assertions check the following rules on every clock:

- A pop strobe appears only after an accepted write-one, and a write-one to an empty FIFO leaves the index frozen.
- An empty FIFO drops its flag.
- The wakeup flag survives a simultaneous clear.
- No request line is raised without its enable.
- The host-interface error flag is gated by its enable.

Only the directed scenarios show the values themselves. These include the group AND-OR results under different flag and enable patterns, the module flag not being gated by bit 7, and enables being read back after writes. They also include flag bits ignoring writes, the exact read-index sequence through a wrap, and the flag value after each pop as the level falls to zero.

// File: rtl/irq_sum_pkg.sv
package irq_sum_pkg;
  // Enable bit positions; flag bit = enable bit + FLAG_OFS
  localparam int EN_MOD   = 7;
  localparam int EN_PROT  = 6;
  localparam int EN_HIF   = 5;
  localparam int EN_WAKE  = 4;
  localparam int EN_FNEB  = 3;
  localparam int EN_FNEA  = 2;
  localparam int EN_RXB   = 1;
  localparam int EN_TXB   = 0;
  localparam int FLAG_OFS = 8;
  localparam int SRC_N    = 7;   // summary flags below the module flag
  localparam int RXF_N    = 2;   // receive FIFOs: 0 = A, 1 = B
endpackage

// File: rtl/irq_group_or.sv
module irq_group_or #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic [W-1:0] src_en,
  input  logic         gate,
  output logic         sum_q
);
  logic sum_d;

  always_comb begin
    sum_d = gate & (|(src & src_en));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sum_q <= 1'b0;
    else        sum_q <= sum_d;
  end

  AST_GRP_NO_ENABLE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_en == '0) |=> !sum_q);  // R2
endmodule

// File: rtl/rxf_ack_ctrl.sv
module rxf_ack_ctrl #(
  parameter int DEPTH = 8,
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic             ack,
  output logic             flag_q,
  output logic [IDX_W-1:0] idx_q,
  output logic             pop_q
);
  logic             accept;
  logic             flag_d;
  logic             pop_d;
  logic [IDX_W-1:0] idx_d;

  always_comb begin
    accept = ack && (lvl != '0);
    pop_d  = accept;
    idx_d  = idx_q;
    flag_d = (lvl != '0);
    if (accept) begin
      idx_d  = (idx_q == IDX_W'(DEPTH - 1)) ? '0 : idx_q + 1'b1;
      flag_d = (lvl > LVL_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      idx_q  <= '0;
      pop_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      idx_q  <= idx_d;
      pop_q  <= pop_d;
    end
  end

  AST_POP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    pop_q |-> ($past(ack) && ($past(lvl) != '0)));  // R9
  AST_IDX_MOVES_ONLY_ON_POP: assert property (@(posedge clk) disable iff (!rst_n)
    !pop_q |-> $stable(idx_q));  // R9
  AST_EMPTY_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && (lvl == '0)) |=> (!pop_q && $stable(idx_q)));  // R11
  AST_EMPTY_DROPS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (lvl == '0) |=> !flag_q);  // R10
endmodule

// File: rtl/irq_summary_reg.sv
module irq_summary_reg
  import irq_sum_pkg::*;
#(
  parameter int PROT_N     = 8,
  parameter int HIF_N      = 4,
  parameter int RXB_N      = 4,
  parameter int TXB_N      = 4,
  parameter int FIFO_DEPTH = 8,
  localparam int IDX_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PROT_N-1:0] prot_flags,
  input  logic [PROT_N-1:0] prot_en,
  input  logic [HIF_N-1:0]  hif_flags,
  input  logic [RXB_N-1:0]  rxb_flags,
  input  logic [RXB_N-1:0]  rxb_en,
  input  logic [TXB_N-1:0]  txb_flags,
  input  logic [TXB_N-1:0]  txb_en,
  input  logic              wake_a,
  input  logic              wake_b,
  input  logic [LVL_W-1:0]  fifo_a_lvl,
  input  logic [LVL_W-1:0]  fifo_b_lvl,
  input  logic              wr_en,
  input  logic [15:0]       wr_data,
  output logic [15:0]       rd_data,
  output logic [SRC_N-1:0]  irq_src,
  output logic              irq_mod,
  output logic [IDX_W-1:0]  fifo_a_idx,
  output logic [IDX_W-1:0]  fifo_b_idx,
  output logic              fifo_a_pop,
  output logic              fifo_b_pop
);
  // Reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_n_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_n_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n_q    <= rst_meta_q;
    end
  end

  // Enable byte
  logic [7:0] en_q, en_d;
  always_comb en_d = wr_en ? wr_data[7:0] : en_q;

  // Wakeup flag: a set in the same cycle beats a clear
  logic wake_q, wake_d, wake_clr;
  always_comb begin
    wake_clr = wr_en & wr_data[FLAG_OFS + EN_WAKE];
    wake_d   = (wake_a | wake_b) | (wake_q & ~wake_clr);
  end

  // Group summaries
  logic prot_q, hif_q, rxb_q, txb_q;

  irq_group_or #(.W(PROT_N)) u_prot (
    .clk(clk), .rst_n(rst_n_q), .src(prot_flags), .src_en(prot_en),
    .gate(1'b1), .sum_q(prot_q));
  irq_group_or #(.W(HIF_N)) u_hif (
    .clk(clk), .rst_n(rst_n_q), .src(hif_flags), .src_en({HIF_N{1'b1}}),
    .gate(en_q[EN_HIF]), .sum_q(hif_q));
  irq_group_or #(.W(RXB_N)) u_rxb (
    .clk(clk), .rst_n(rst_n_q), .src(rxb_flags), .src_en(rxb_en),
    .gate(1'b1), .sum_q(rxb_q));
  irq_group_or #(.W(TXB_N)) u_txb (
    .clk(clk), .rst_n(rst_n_q), .src(txb_flags), .src_en(txb_en),
    .gate(1'b1), .sum_q(txb_q));

  // Receive FIFO acknowledge control, one per FIFO
  logic [RXF_N-1:0][LVL_W-1:0] lvl_arr;
  logic [RXF_N-1:0][IDX_W-1:0] idx_arr;
  logic [RXF_N-1:0]            fne_q;
  logic [RXF_N-1:0]            pop_arr;

  assign lvl_arr = {fifo_b_lvl, fifo_a_lvl};

  for (genvar j = 0; j < RXF_N; j++) begin : g_rxf
    rxf_ack_ctrl #(.DEPTH(FIFO_DEPTH)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n_q),
      .lvl   (lvl_arr[j]),
      .ack   (wr_en & wr_data[FLAG_OFS + EN_FNEA + j]),
      .flag_q(fne_q[j]),
      .idx_q (idx_arr[j]),
      .pop_q (pop_arr[j])
    );
  end

  assign fifo_a_idx = idx_arr[0];
  assign fifo_b_idx = idx_arr[1];
  assign fifo_a_pop = pop_arr[0];
  assign fifo_b_pop = pop_arr[1];

  // Flag vector, index k = flag bit k + FLAG_OFS
  logic [SRC_N-1:0] fl;
  logic             mod_flag;
  logic [SRC_N-1:0] irq_src_d;
  logic             irq_mod_d;

  always_comb begin
    fl        = {prot_q, hif_q, wake_q, fne_q[1], fne_q[0], rxb_q, txb_q};
    mod_flag  = |(fl & en_q[SRC_N-1:0]);
    irq_src_d = fl & en_q[SRC_N-1:0];
    irq_mod_d = mod_flag & en_q[EN_MOD];
    rd_data   = {mod_flag, fl, en_q};
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) begin
      en_q    <= '0;
      wake_q  <= 1'b0;
      irq_src <= '0;
      irq_mod <= 1'b0;
    end else begin
      en_q    <= en_d;
      wake_q  <= wake_d;
      irq_src <= irq_src_d;
      irq_mod <= irq_mod_d;
    end
  end

  AST_WAKE_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n_q)
    (wake_a || wake_b) |=> rd_data[FLAG_OFS + EN_WAKE]);  // R8
  AST_WAKE_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n_q)
    (wr_en && wr_data[FLAG_OFS + EN_WAKE] && !wake_a && !wake_b)
      |=> !rd_data[FLAG_OFS + EN_WAKE]);  // R7
  AST_HIF_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    rd_data[FLAG_OFS + EN_HIF] |-> $past(en_q[EN_HIF]));  // R3
  AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    ((irq_src & ~$past(en_q[SRC_N-1:0])) == '0));  // R5
  AST_MOD_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n_q)
    irq_mod |-> ($past(en_q[EN_MOD]) && $past(mod_flag)));  // R5
endmodule

// File: tb/tb_irq_summary_reg.sv
module tb_irq_summary_reg;
  localparam int DEPTH = 8;
  localparam int IW = $clog2(DEPTH);
  localparam int LW = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n;
  logic [7:0] prot_flags, prot_en;
  logic [3:0] hif_flags, rxb_flags, rxb_en, txb_flags, txb_en;
  logic wake_a, wake_b, wr_en;
  logic [LW-1:0] lvl_a, lvl_b;
  logic [15:0] wr_data, rd_data;
  logic [6:0] irq_src;
  logic irq_mod, pop_a, pop_b;
  logic [IW-1:0] idx_a, idx_b;

  int checks = 0;
  int failures = 0;
  logic [7:0] en_sh = 8'h00;
  int exp_idx_a = 0;

  always #5 clk = ~clk;

  irq_summary_reg #(.PROT_N(8), .HIF_N(4), .RXB_N(4), .TXB_N(4), .FIFO_DEPTH(DEPTH)) dut (
    .clk(clk), .rst_n(rst_n), .prot_flags(prot_flags), .prot_en(prot_en),
    .hif_flags(hif_flags), .rxb_flags(rxb_flags), .rxb_en(rxb_en),
    .txb_flags(txb_flags), .txb_en(txb_en), .wake_a(wake_a), .wake_b(wake_b),
    .fifo_a_lvl(lvl_a), .fifo_b_lvl(lvl_b), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .irq_src(irq_src), .irq_mod(irq_mod),
    .fifo_a_idx(idx_a), .fifo_b_idx(idx_b), .fifo_a_pop(pop_a), .fifo_b_pop(pop_b));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // one-cycle write; returns at the negedge after the capturing edge
  task automatic wr(input logic [7:0] flag_bits);
    wr_en = 1'b1;
    wr_data = {flag_bits, en_sh};
    tick(1);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  task automatic t_reset;
    chk("R1 rd_data", rd_data, 0);
    chk("R1 irq_src", irq_src, 0);
    chk("R1 irq_mod", irq_mod, 0);
    chk("R1 pops", {pop_a, pop_b}, 0);
    chk("R1 idx", {idx_a, idx_b}, 0);
  endtask

  task automatic t_write_access;
    en_sh = 8'hA5;
    wr(8'h00);
    chk("R6 enable readback", rd_data, 16'h00A5);
    en_sh = 8'hFF;
    wr(8'hFF);  // every flag bit written one, FIFOs empty, no sources
    chk("R6 flag bits ignore writes", rd_data, 16'h00FF);
    chk("R11 no pop on empty FIFOs", {pop_a, pop_b}, 0);
    chk("R11 idx unchanged", {idx_a, idx_b}, 0);
  endtask

  task automatic t_groups;
    prot_flags = 8'h10; prot_en = 8'h10;
    tick(1);
    chk("R2 protocol flag set", rd_data[14], 1);
    chk("R4 module flag set", rd_data[15], 1);
    tick(1);
    chk("R5 protocol irq", irq_src[6], 1);
    chk("R5 module irq", irq_mod, 1);
    prot_en = 8'h01;
    tick(2);
    chk("R2 mismatched enable clears", rd_data[14], 0);
    chk("R5 protocol irq drops", irq_src[6], 0);
    chk("R5 module irq drops", irq_mod, 0);
    prot_flags = 8'h00;
    rxb_flags = 4'b0010; rxb_en = 4'b0011;
    en_sh = 8'hFD;
    wr(8'h00);
    tick(1);
    chk("R2 rx buffer flag ungated", rd_data[9], 1);
    chk("R4 module flag masked by enable", rd_data[15], 0);
    chk("R5 rx irq masked", irq_src[1], 0);
    en_sh = 8'hFF;
    wr(8'h00);
    tick(1);
    chk("R4 module flag with enable", rd_data[15], 1);
    chk("R5 rx irq", irq_src[1], 1);
    rxb_flags = 4'b0000; txb_flags = 4'b0001; txb_en = 4'b0001;
    en_sh = 8'h7F;
    wr(8'h00);
    tick(1);
    chk("R2 rx buffer cleared", rd_data[9], 0);
    chk("R2 tx buffer flag", rd_data[8], 1);
    chk("R4 module flag ignores bit7", rd_data[15], 1);
    chk("R5 module irq off without bit7", irq_mod, 0);
    chk("R5 tx irq", irq_src[0], 1);
    txb_flags = 4'b0000;
    en_sh = 8'hFF;
    wr(8'h00);
    tick(1);
  endtask

  task automatic t_hif;
    hif_flags = 4'b0100;
    en_sh = 8'hDF;
    wr(8'h00);
    tick(2);
    chk("R3 hif flag gated off", rd_data[13], 0);
    en_sh = 8'hFF;
    wr(8'h00);
    tick(1);
    chk("R3 hif flag with enable", rd_data[13], 1);
    hif_flags = 4'b0000;
    tick(1);
    chk("R3 hif flag clears", rd_data[13], 0);
  endtask

  task automatic t_wakeup;
    wake_a = 1'b1; tick(1); wake_a = 1'b0;
    chk("R7 wake from channel A", rd_data[12], 1);
    wr(8'h00);
    chk("R6 writing zero keeps wake", rd_data[12], 1);
    wr(8'h10);
    chk("R7 write one clears wake", rd_data[12], 0);
    wake_b = 1'b1; tick(1); wake_b = 1'b0;
    chk("R7 wake from channel B", rd_data[12], 1);
    wr(8'h10);
    wake_a = 1'b1;
    wr(8'h10);
    wake_a = 1'b0;
    chk("R8 set wins over clear", rd_data[12], 1);
    wr(8'h10);
    chk("R7 cleared after race", rd_data[12], 0);
  endtask

  task automatic ack_a;
    int lv;
    lv = int'(lvl_a);
    wr(8'h04);
    exp_idx_a = (exp_idx_a + 1) % DEPTH;
    chk("R9 pop A strobe", pop_a, 1);
    chk("R9 idx A", idx_a, exp_idx_a);
    chk("R10 flag A after pop", rd_data[10], (lv > 1) ? 1 : 0);
    chk("R9 no pop on B", pop_b, 0);
    lvl_a = LW'(lv - 1);
    tick(1);
    chk("R9 pop A single cycle", pop_a, 0);
    chk("R10 flag A follows level", rd_data[10], (lv - 1 != 0) ? 1 : 0);
  endtask

  task automatic t_fifo_a;
    lvl_a = LW'(3);
    tick(1);
    chk("R10 flag A not empty", rd_data[10], 1);
    repeat (3) ack_a();
    lvl_a = LW'(DEPTH);
    tick(1);
    for (int i = 0; i < DEPTH; i++) ack_a();  // wraps the index
    chk("R9 idx A after wrap", idx_a, (3 + DEPTH) % DEPTH);
  endtask

  task automatic t_fifo_b;
    lvl_b = '0;
    wr(8'h08);
    chk("R11 no pop B when empty", pop_b, 0);
    chk("R11 idx B held", idx_b, 0);
    chk("R10 flag B empty", rd_data[11], 0);
    lvl_b = LW'(2);
    tick(1);
    wr(8'h08);
    chk("R9 pop B", pop_b, 1);
    chk("R9 idx B", idx_b, 1);
    chk("R10 flag B stays set", rd_data[11], 1);
    chk("R9 no pop on A", pop_a, 0);
  endtask

  initial begin
    #2_000_000;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    prot_flags = '0; prot_en = '0; hif_flags = '0;
    rxb_flags = '0; rxb_en = '0; txb_flags = '0; txb_en = '0;
    wake_a = 1'b0; wake_b = 1'b0; lvl_a = '0; lvl_b = '0;
    wr_en = 1'b0; wr_data = '0;
    tick(3);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_write_access();
    t_groups();
    t_hif();
    t_wakeup();
    t_fifo_a();
    t_fifo_b();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule